// File: doc/BRIEF.md
# Timer Channel with Write Arbitration

This block is one up-counting timer channel. A free-running counter advances on each cycle that an external prescaler raises its count-enable strobe. A compare register sits beside it, and when the two become equal the channel emits a one-cycle match pulse and sets a sticky status flag. Software reaches the counter, the compare register and the flag over a two-state register bus. The first state (T1) carries the address and the write intent. The second state (T2) carries the data, which takes effect at the clock edge that ends T2.

The block settles every case where a bus write and hardware activity land in the same cycle. A counter write in T2 beats a count strobe in that cycle. A compare-register write in T2 cancels the match the comparator would have raised in that cycle. A match that coincides with a flag clear keeps the flag set.

Top module: `tmr_arb_chan`

## Requirements
- R1: After reset the counter reads 0x0000, the compare register reads 0xFFFF, the status flag is 0 and the match output is low.
- R2: In a cycle with count-enable high and no counter write in T2, the counter rises by exactly one at the next edge, wrapping from 0xFFFF to 0x0000. With count-enable low and no counter write, it holds.
- R3: A write is a T1 cycle (bus_t1 high, bus_we high, bus_addr valid) followed by a T2 cycle carrying bus_wdata. The value is readable from the cycle after T2. The map is: address 0 counter, 1 compare register, 2 status. A T1 with bus_we low starts no write.
- R4: When count-enable is high during the T2 cycle of a counter write, the counter takes the written value exactly. The increment is lost and is not applied later.
- R5: A match event occurs in a cycle where the counter equals the compare register and, in the previous cycle, the counter was incremented or written, or the compare register was written with a different value. Each event gives a single-cycle pulse on match_o in the following cycle. A counter stalled at the compare value does not repeat the pulse.
- R6: In the T2 cycle of a compare-register write, no match event occurs even if the counter equals the old compare value.
- R7: Writing the compare register with the value it already holds also suppresses the match in its T2 cycle, and does not re-arm the comparator for later cycles.
- R8: A match event sets the status flag (status bit 0) at the same edge that raises match_o. A status write with bit 0 equal to 1 clears the flag. A status write with bit 0 equal to 0 leaves it unchanged.
- R9: When a match event and a flag-clearing write's T2 fall in the same cycle, the flag ends set.
- R10: bus_rdata shows the register that bus_addr selects, with status in bit 0 and other bits zero, and zero for unmapped addresses. Reading changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count strobe from the prescaler |
| bus_t1 | input | 1 | Marks the address state of a bus cycle |
| bus_we | input | 1 | Write intent, sampled in T1 |
| bus_addr | input | ADDR_W (2) | Register address, sampled in T1 and used for reads |
| bus_wdata | input | CNT_W (16) | Write data, sampled in T2 |
| bus_rdata | output | CNT_W (16) | Read data for bus_addr |
| match_o | output | 1 | One-cycle compare-match pulse |
| flag_o | output | 1 | Sticky match status flag |

## Verification
The bench builds the channel with a 16-bit counter, a 2-bit address and the registered match stage. At 16 bits the counter can be preloaded to 0xFFFE and carried through the wrap in three strobes, which keeps the wrap match within a short run. The registered stage places every pulse exactly one cycle after its event, so the scoreboard can predict the cycle of each pulse and treat any stray pulse as an error. The same-cycle conflicts are staged by putting a count strobe in T1 so that equality arises precisely in T2.

// File: rtl/tac_pkg.sv
package tac_pkg;

   typedef enum logic [1:0] {
      TAC_SEL_NONE = 2'd0,
      TAC_SEL_CNT  = 2'd1,
      TAC_SEL_CMP  = 2'd2,
      TAC_SEL_STS  = 2'd3
   } tac_sel_e;

   function automatic tac_sel_e tac_decode(
      input int unsigned a,
      input int unsigned a_cnt,
      input int unsigned a_cmp,
      input int unsigned a_sts
   );
      tac_sel_e s;
      if (a == a_cnt)      s = TAC_SEL_CNT;
      else if (a == a_cmp) s = TAC_SEL_CMP;
      else if (a == a_sts) s = TAC_SEL_STS;
      else                 s = TAC_SEL_NONE;
      return s;
   endfunction

endpackage

// File: rtl/tac_bus_phase.sv
module tac_bus_phase
   import tac_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned A_CNT  = 0,
   parameter int unsigned A_CMP  = 1,
   parameter int unsigned A_STS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_t1,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              wr_cnt,
   output logic              wr_cmp,
   output logic              wr_sts
);

   tac_sel_e t1_sel;
   tac_sel_e t2_sel_q;

   always_comb begin
      if (bus_t1 && bus_we)
         t1_sel = tac_decode(int'(bus_addr), A_CNT, A_CMP, A_STS);
      else
         t1_sel = TAC_SEL_NONE;
   end

   // The target chosen in T1 is held one cycle; that cycle is T2.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) t2_sel_q <= TAC_SEL_NONE;
      else        t2_sel_q <= t1_sel;
   end

   assign wr_cnt = (t2_sel_q == TAC_SEL_CNT);
   assign wr_cmp = (t2_sel_q == TAC_SEL_CMP);
   assign wr_sts = (t2_sel_q == TAC_SEL_STS);

endmodule

// File: rtl/tac_counter.sv
module tac_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cen,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] cnt_q,
   output logic         cnt_moved
);

   localparam logic [W-1:0] ONE = W'(1);

   // Bus load outranks the count strobe; the strobe is simply dropped.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (wr_en) cnt_q <= wr_data;
      else if (cen)   cnt_q <= cnt_q + ONE;
   end

   assign cnt_moved = wr_en | cen;

endmodule

// File: rtl/tac_compare.sv
module tac_compare #(
   parameter int unsigned W         = 16,
   parameter logic [W-1:0] RST_VAL  = '1,
   parameter bit          PULSE_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt_q,
   input  logic         cnt_moved,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] cmp_q,
   output logic         match_ev,
   output logic         match_o
);

   logic arm_q;
   logic arm_d;
   logic equal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cmp_q <= RST_VAL;
      else if (wr_en) cmp_q <= wr_data;
   end

   // A rewrite with the held value must not arm the comparator.
   assign arm_d = cnt_moved | (wr_en & (wr_data != cmp_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q <= 1'b0;
      else        arm_q <= arm_d;
   end

   assign equal    = (cnt_q == cmp_q);
   assign match_ev = equal & arm_q & ~wr_en;

   generate
      if (PULSE_REG) begin : g_pulse_ff
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= match_ev;
         end
         assign match_o = pulse_q;
      end else begin : g_pulse_comb
         assign match_o = match_ev;
      end
   endgenerate

endmodule

// File: rtl/tac_status.sv
module tac_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_req,
   output logic flag_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_ev)  flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
   end

endmodule

// File: rtl/tmr_arb_chan.sv
module tmr_arb_chan
   import tac_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned A_CNT     = 0,
   parameter int unsigned A_CMP     = 1,
   parameter int unsigned A_STS     = 2,
   parameter int unsigned STS_BIT   = 0,
   parameter bit          PULSE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              bus_t1,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              match_o,
   output logic              flag_o
);

   localparam int unsigned  N_ADDR  = 1 << ADDR_W;
   localparam logic [CNT_W-1:0] CMP_RST = '1;

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
      $error("tmr_arb_chan: CNT_W must lie in 2..64");
   end
   if (A_CNT >= N_ADDR || A_CMP >= N_ADDR || A_STS >= N_ADDR) begin : g_bad_addr
      $error("tmr_arb_chan: register address exceeds ADDR_W");
   end
   if (A_CNT == A_CMP || A_CNT == A_STS || A_CMP == A_STS) begin : g_dup_addr
      $error("tmr_arb_chan: register addresses must differ");
   end
   if (STS_BIT >= CNT_W) begin : g_bad_bit
      $error("tmr_arb_chan: STS_BIT outside the data bus");
   end

   logic             wr_cnt;
   logic             wr_cmp;
   logic             wr_sts;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_moved;
   logic [CNT_W-1:0] cmp_q;
   logic             match_ev;
   logic             flag_q;
   logic             clr_req;
   tac_sel_e         rd_sel;

   tac_bus_phase #(
      .ADDR_W (ADDR_W),
      .A_CNT  (A_CNT),
      .A_CMP  (A_CMP),
      .A_STS  (A_STS)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_t1   (bus_t1),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .wr_cnt   (wr_cnt),
      .wr_cmp   (wr_cmp),
      .wr_sts   (wr_sts)
   );

   tac_counter #(
      .W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .cen       (cnt_en),
      .wr_en     (wr_cnt),
      .wr_data   (bus_wdata),
      .cnt_q     (cnt_q),
      .cnt_moved (cnt_moved)
   );

   tac_compare #(
      .W         (CNT_W),
      .RST_VAL   (CMP_RST),
      .PULSE_REG (PULSE_REG)
   ) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_q     (cnt_q),
      .cnt_moved (cnt_moved),
      .wr_en     (wr_cmp),
      .wr_data   (bus_wdata),
      .cmp_q     (cmp_q),
      .match_ev  (match_ev),
      .match_o   (match_o)
   );

   assign clr_req = wr_sts & bus_wdata[STS_BIT];

   tac_status u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_ev  (match_ev),
      .clr_req (clr_req),
      .flag_q  (flag_q)
   );

   assign flag_o = flag_q;

   assign rd_sel = tac_decode(int'(bus_addr), A_CNT, A_CMP, A_STS);

   always_comb begin
      bus_rdata = '0;
      case (rd_sel)
         TAC_SEL_CNT: bus_rdata = cnt_q;
         TAC_SEL_CMP: bus_rdata = cmp_q;
         TAC_SEL_STS: bus_rdata[STS_BIT] = flag_q;
         default:     bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tac_chk.sv
module tac_chk #(
   parameter int unsigned W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cen,
   input logic         wr_cnt,
   input logic         wr_cmp,
   input logic         clr_req,
   input logic [W-1:0] wr_data,
   input logic [W-1:0] cnt_q,
   input logic [W-1:0] cmp_q,
   input logic         match_ev,
   input logic         flag
);

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cen && !wr_cnt) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen && !wr_cnt) |=> $stable(cnt_q));

   // R4
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (cnt_q == $past(wr_data)));

   // R3
   cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmp |=> (cmp_q == $past(wr_data)));

   // R6
   cmp_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmp && !flag) |=> !flag);

   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_ev |=> flag);

   // R8
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !match_ev) |=> !flag);

endmodule

bind tmr_arb_chan tac_chk #(.W(CNT_W)) u_tac_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cen      (cnt_en),
   .wr_cnt   (wr_cnt),
   .wr_cmp   (wr_cmp),
   .clr_req  (clr_req),
   .wr_data  (bus_wdata),
   .cnt_q    (cnt_q),
   .cmp_q    (cmp_q),
   .match_ev (match_ev),
   .flag     (flag_q)
);

// File: tb/tmr_arb_chan_bench.sv
`timescale 1ns/100ps
module tmr_arb_chan_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        bus_t1 = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        match_o;
   logic        flag_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   // requirement-level model state
   logic [15:0] m_cnt = 16'h0000;
   logic [15:0] m_cmp = 16'hFFFF;
   bit m_arm = 1'b0, m_flag = 1'b0;
   bit p_v = 1'b0, p_we = 1'b0;
   logic [1:0] p_a = 2'd0;
   int exp_q[$];

   always #2.5 clk = ~clk;

   tmr_arb_chan u_tmr_arb_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_en    (cnt_en),
      .bus_t1    (bus_t1),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .match_o   (match_o),
      .flag_o    (flag_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // Scoreboard monitor: pops predicted pulse cycles.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (exp_q.size() > 0 && exp_q[0] == cyc) begin
            checks++;
            if (!match_o) begin
               errors++;
               $display("FAIL %s: match pulse missing in cycle %0d (actual 0, expected 1)", cur_req, cyc);
            end
            void'(exp_q.pop_front());
         end else if (match_o) begin
            checks++;
            errors++;
            $display("FAIL %s: stray match pulse in cycle %0d (actual 1, expected 0)", cur_req, cyc);
         end
      end
   end

   // Model of one cycle's effect, taken from the requirements.
   task automatic model_step(input bit cen, input bit t1, input bit we,
                             input logic [1:0] a, input logic [15:0] d);
      bit wcnt, wcmp, wsts, ev, arm_n;
      wcnt = p_v && p_we && (p_a == 2'd0);
      wcmp = p_v && p_we && (p_a == 2'd1);
      wsts = p_v && p_we && (p_a == 2'd2);
      ev = (m_cnt == m_cmp) && m_arm && !wcmp;
      if (ev) exp_q.push_back(cyc + 1);
      arm_n = wcnt || cen || (wcmp && (d != m_cmp));
      if (wcnt)     m_cnt = d;
      else if (cen) m_cnt = m_cnt + 16'd1;
      if (wcmp) m_cmp = d;
      if (ev)                m_flag = 1'b1;
      else if (wsts && d[0]) m_flag = 1'b0;
      m_arm = arm_n;
      p_v = t1; p_we = we; p_a = a;
   endtask

   task automatic drive(input bit cen, input bit t1, input bit we,
                        input logic [1:0] a, input logic [15:0] d);
      cnt_en = cen; bus_t1 = t1; bus_we = we; bus_addr = a; bus_wdata = d;
      model_step(cen, t1, we, a, d);
      @(posedge clk);
      #1;
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [15:0] d,
                            input bit cen_t1, input bit cen_t2);
      drive(cen_t1, 1'b1, 1'b1, a, 16'h0);
      drive(cen_t2, 1'b0, 1'b0, a, d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 2'd0, 16'h0);
   endtask

   task automatic check_val(input string req, input string what,
                            input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rd_chk(input logic [1:0] a, input string req);
      logic [15:0] e;
      bus_t1 = 1'b0;
      bus_addr = a;
      #0.2;
      case (a)
         2'd0:    e = m_cnt;
         2'd1:    e = m_cmp;
         2'd2:    e = {15'd0, m_flag};
         default: e = 16'h0;
      endcase
      check_val(req, $sformatf("read addr %0d", a), bus_rdata, e);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end (actual timeout, expected finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check_val("R1", "match_o in reset", {15'd0, match_o}, 16'h0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      rd_chk(2'd0, "R1");
      rd_chk(2'd1, "R1");
      rd_chk(2'd2, "R1");
      check_val("R1", "flag_o after reset", {15'd0, flag_o}, 16'h0);

      // R3 compare write, R5 match from counting, R2 count
      cur_req = "R5";
      bus_write(2'd1, 16'h0005, 1'b0, 1'b0);
      rd_chk(2'd1, "R3");
      for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
      idle(1);
      rd_chk(2'd0, "R2");
      rd_chk(2'd2, "R8");
      check_val("R8", "flag_o after match", {15'd0, flag_o}, 16'h1);

      // R8 write 0 keeps flag, write 1 clears it
      cur_req = "R8";
      bus_write(2'd2, 16'h0000, 1'b0, 1'b0);
      rd_chk(2'd2, "R8");
      bus_write(2'd2, 16'h0001, 1'b0, 1'b0);
      rd_chk(2'd2, "R8");
      check_val("R8", "flag_o after clear", {15'd0, flag_o}, 16'h0);

      // R5 stalled at equality gives a single pulse
      cur_req = "R5";
      bus_write(2'd1, 16'h0020, 1'b0, 1'b0);
      bus_write(2'd0, 16'h0020, 1'b0, 1'b0);
      idle(5);
      rd_chk(2'd2, "R5");

      // R4 counter write beats count strobe in T2
      cur_req = "R4";
      bus_write(2'd0, 16'h0100, 1'b1, 1'b1);
      rd_chk(2'd0, "R4");
      drive(1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
      rd_chk(2'd0, "R4");
      bus_write(2'd2, 16'h0001, 1'b0, 1'b0);

      // R6 compare write cancels a same-cycle match
      cur_req = "R6";
      bus_write(2'd1, 16'h0030, 1'b0, 1'b0);
      bus_write(2'd0, 16'h002F, 1'b0, 1'b0);
      bus_write(2'd1, 16'h0040, 1'b1, 1'b0);
      idle(3);
      check_val("R6", "flag_o after cancelled match", {15'd0, flag_o}, 16'h0);
      rd_chk(2'd1, "R6");

      // R7 same-value compare write suppresses and does not re-arm
      cur_req = "R7";
      bus_write(2'd0, 16'h003F, 1'b0, 1'b0);
      bus_write(2'd1, 16'h0040, 1'b1, 1'b0);
      idle(4);
      check_val("R7", "flag_o after same-value write", {15'd0, flag_o}, 16'h0);
      rd_chk(2'd0, "R7");

      // R9 set beats clear in the same cycle
      cur_req = "R9";
      bus_write(2'd0, 16'h004F, 1'b0, 1'b0);
      bus_write(2'd1, 16'h0050, 1'b0, 1'b0);
      bus_write(2'd2, 16'h0001, 1'b1, 1'b0);
      idle(1);
      check_val("R9", "flag_o after set with clear", {15'd0, flag_o}, 16'h1);
      rd_chk(2'd2, "R9");

      // R2 wrap, with a match on zero
      cur_req = "R2";
      bus_write(2'd2, 16'h0001, 1'b0, 1'b0);
      bus_write(2'd1, 16'h0000, 1'b0, 1'b0);
      bus_write(2'd0, 16'hFFFE, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
      idle(1);
      rd_chk(2'd0, "R2");
      check_val("R2", "flag_o after wrap match", {15'd0, flag_o}, 16'h1);

      // R3 a T1 without write intent changes nothing
      cur_req = "R3";
      drive(1'b0, 1'b1, 1'b0, 2'd0, 16'h0);
      drive(1'b0, 1'b0, 1'b0, 2'd0, 16'h1234);
      idle(1);
      rd_chk(2'd0, "R3");

      // R10 repeated reads leave state untouched
      cur_req = "R10";
      rd_chk(2'd3, "R10");
      rd_chk(2'd2, "R10");
      idle(1);
      rd_chk(2'd2, "R10");
      rd_chk(2'd0, "R10");
      rd_chk(2'd1, "R10");
      idle(2);

      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R5: pending pulses actual %0d expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule